// File: doc/BRIEF.md
# Message Indication Byte Serializer

This block takes one decoded PCI Express message record at a time and plays it out as a narrow indication stream: a valid pulse, a 5-bit type code that stays fixed for the pulse, and an 8-bit data bus carrying one byte per cycle. Every message opens with the two requester ID bytes. The type code then decides how many more bytes follow and what they hold: a power-limit payload, two latency values, a buffer flush/fill code, or a vendor ID with an optional payload Dword.

A record is loaded through a simple valid/ready handshake. Once a pulse starts, it runs on consecutive cycles with no stall, because the consumer cannot push back. After each pulse the block holds its input closed for a parameterised number of idle cycles, so pulses never touch. Codes in the reserved range are taken from the input and dropped, and a one-cycle error flag reports them.

Top module: `msg_byte_serializer`

## Requirements
- R1: After reset, msg_valid is 0, in_ready is 1 and bad_type is 0.
- R2: A record with a code of 0 to 24 that is accepted (in_valid and in_ready high at a clock edge) makes msg_valid rise in the next cycle. The first byte is in_req_id[15:8] (bus number) and the second byte is in_req_id[7:0] (device/function).
- R3: The pulse lasts 2 cycles for codes 0 to 14, 18 and 21 to 24. It lasts 3 cycles for code 17, 6 cycles for codes 15 and 16, and for codes 19 and 20 it lasts 4 cycles when in_has_data is 0 and 8 cycles when it is 1.
- R4: For code 15, bytes 3 to 6 are in_payload[7:0], [15:8], [23:16] and [31:24], in that order.
- R5: For code 16, bytes 3 and 4 are in_snoop_lat low then high, and bytes 5 and 6 are in_nosnoop_lat low then high.
- R6: For code 17, byte 3 is in_obff_code.
- R7: For codes 19 and 20, bytes 3 and 4 are in_vendor_id low then high. When in_has_data is 1, bytes 5 to 8 are in_payload, least significant byte first.
- R8: msg_type equals the accepted code and stays constant on every cycle of the pulse.
- R9: Once started, a pulse runs on consecutive cycles without any gap.
- R10: in_ready is 0 for the whole pulse and for GAP cycles after its last cycle, so that at least one idle cycle separates two pulses.
- R11: A code of 25 to 31 is accepted but never emitted. bad_type is 1 for exactly the one cycle after it is accepted, and in_ready stays 1.
- R12: msg_data is 0 whenever msg_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record present |
| in_ready | output | 1 | Block can take a record |
| in_type | input | 5 | Message type code |
| in_req_id | input | 16 | Requester ID (bus in upper byte) |
| in_has_data | input | 1 | Vendor-defined message carries a payload Dword |
| in_payload | input | 32 | Payload Dword |
| in_snoop_lat | input | 16 | Snoop latency value |
| in_nosnoop_lat | input | 16 | No-snoop latency value |
| in_obff_code | input | 8 | Buffer flush/fill code |
| in_vendor_id | input | 16 | Vendor ID |
| msg_valid | output | 1 | Indication pulse |
| msg_type | output | 5 | Type code of the current pulse |
| msg_data | output | 8 | Current parameter byte |
| bad_type | output | 1 | One-cycle flag for a dropped reserved code |

## Verification
Dropping a reserved code leaves in_ready high, so the cycle in which bad_type is raised is also a cycle in which the next record can be accepted. The bench provokes this by offering a reserved code and then, with no pause, a legal record. It checks that the flag and the handshake are both high in that shared cycle. It then checks that the flag falls exactly as the legal record's pulse starts, and that the pulse arrives complete with the right bytes.

// File: rtl/msg_byte_serializer.sv
module msg_byte_serializer #(
  parameter int GAP = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [4:0]  in_type,
  input  logic [15:0] in_req_id,
  input  logic        in_has_data,
  input  logic [31:0] in_payload,
  input  logic [15:0] in_snoop_lat,
  input  logic [15:0] in_nosnoop_lat,
  input  logic [7:0]  in_obff_code,
  input  logic [15:0] in_vendor_id,
  output logic        msg_valid,
  output logic [4:0]  msg_type,
  output logic [7:0]  msg_data,
  output logic        bad_type
);
  localparam int GW = $clog2(GAP + 1);

  logic [63:0]   shreg;
  logic [3:0]    left;
  logic [GW-1:0] gap_cnt;
  logic [4:0]    type_q;
  logic          err_q;
  logic [63:0]   packed_rec;
  logic [3:0]    rec_len;

  wire rsvd = in_type > 5'd24;
  wire take = in_valid && in_ready;

  assign in_ready  = (left == 4'd0) && (gap_cnt == '0);
  assign msg_valid = left != 4'd0;
  assign msg_type  = type_q;
  assign msg_data  = msg_valid ? shreg[7:0] : 8'd0;
  assign bad_type  = err_q;

  always_comb begin
    packed_rec = {48'd0, in_req_id[7:0], in_req_id[15:8]};
    rec_len    = 4'd2;
    case (in_type)
      5'd15: begin
        packed_rec[47:16] = in_payload;
        rec_len = 4'd6;
      end
      5'd16: begin
        packed_rec[47:16] = {in_nosnoop_lat, in_snoop_lat};
        rec_len = 4'd6;
      end
      5'd17: begin
        packed_rec[23:16] = in_obff_code;
        rec_len = 4'd3;
      end
      5'd19, 5'd20: begin
        packed_rec[31:16] = in_vendor_id;
        if (in_has_data) begin
          packed_rec[63:32] = in_payload;
          rec_len = 4'd8;
        end else begin
          rec_len = 4'd4;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      left    <= '0;
      gap_cnt <= '0;
      type_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= take && rsvd;
      if (take && !rsvd) begin
        shreg  <= packed_rec;
        left   <= rec_len;
        type_q <= in_type;
      end else if (left != 4'd0) begin
        shreg <= shreg >> 8;
        left  <= left - 4'd1;
        if (left == 4'd1) gap_cnt <= GW'(GAP);
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n) msg_valid |-> !in_ready); // R10
  AST_GAP_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(msg_valid) |-> !in_ready); // R10
  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (msg_valid && $past(msg_valid)) |-> $stable(msg_type)); // R8
  AST_START_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && in_type <= 5'd24) |=> (msg_valid && msg_data == $past(in_req_id[15:8]))); // R2
  AST_RSVD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && in_type > 5'd24) |=> (!msg_valid && bad_type)); // R11
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) bad_type |-> $past(in_valid && in_type > 5'd24)); // R11
endmodule

// File: tb/msg_byte_serializer_test.sv
module msg_byte_serializer_test;
  localparam int CLK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_type = '0;
  logic [15:0] in_req_id = '0;
  logic        in_has_data = 1'b0;
  logic [31:0] in_payload = '0;
  logic [15:0] in_snoop_lat = '0;
  logic [15:0] in_nosnoop_lat = '0;
  logic [7:0]  in_obff_code = '0;
  logic [15:0] in_vendor_id = '0;
  logic        msg_valid;
  logic [4:0]  msg_type;
  logic [7:0]  msg_data;
  logic        bad_type;

  int total = 0;
  int bad = 0;
  bit done = 0;

  msg_byte_serializer #(.GAP(1)) uut (.*);

  always #(CLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int c, input bit hd);
    if (c == 17) return 3;
    if (c == 15 || c == 16) return 6;
    if (c == 19 || c == 20) return hd ? 8 : 4;
    return 2;
  endfunction

  function automatic string tag_of(input int c, input int i);
    if (i < 2) return "R2";
    if (c == 15) return "R4";
    if (c == 16) return "R5";
    if (c == 17) return "R6";
    return "R7";
  endfunction

  function automatic logic [7:0] exp_byte(input int c, input int i);
    case (i)
      0: return in_req_id[15:8];
      1: return in_req_id[7:0];
      default: ;
    endcase
    if (c == 15) return in_payload[8*(i-2) +: 8];
    if (c == 16) return (i < 4) ? in_snoop_lat[8*(i-2) +: 8] : in_nosnoop_lat[8*(i-4) +: 8];
    if (c == 17) return in_obff_code;
    if (i < 4) return in_vendor_id[8*(i-2) +: 8];
    return in_payload[8*(i-4) +: 8];
  endfunction

  task automatic load(input int c, input bit hd);
    in_type        = 5'(c);
    in_has_data    = hd;
    in_req_id      = 16'hA55A ^ 16'(c * 16'h0731) ^ {15'd0, hd};
    in_payload     = 32'h1234_5678 + 32'(c * 32'h0101_0303);
    in_snoop_lat   = 16'h3C00 + 16'(c * 7);
    in_nosnoop_lat = 16'h0C30 + 16'(c * 11);
    in_obff_code   = 8'h50 + 8'(c);
    in_vendor_id   = 16'hBEE0 + 16'(c);
  endtask

  task automatic collect(input int c, input bit hd);
    int n = 0;
    bit type_ok = 1;
    chk(msg_valid === 1'b1, "R2", msg_valid, 1);
    chk(in_ready === 1'b0, "R10", in_ready, 0);
    while (msg_valid === 1'b1 && n < 12) begin
      logic [7:0] e;
      e = exp_byte(c, n);
      chk(msg_data === e, tag_of(c, n), msg_data, e);
      if (msg_type !== 5'(c)) type_ok = 0;
      n++;
      @(negedge clk);
    end
    chk(type_ok, "R8", msg_type, c);
    chk(n == exp_len(c, hd), "R3 R9", n, exp_len(c, hd));
    chk(in_ready === 1'b0, "R10", in_ready, 0);
    chk(msg_data === 8'd0, "R12", msg_data, 0);
  endtask

  task automatic send(input int c, input bit hd);
    @(negedge clk);
    while (in_ready !== 1'b1) @(negedge clk);
    load(c, hd);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (c > 24) begin
      chk(bad_type === 1'b1 && msg_valid === 1'b0, "R11", {bad_type, msg_valid}, 2);
      chk(in_ready === 1'b1, "R11", in_ready, 1);
      @(negedge clk);
      chk(bad_type === 1'b0 && msg_valid === 1'b0, "R11", {bad_type, msg_valid}, 0);
    end else begin
      collect(c, hd);
    end
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(msg_valid === 1'b0 && in_ready === 1'b1 && bad_type === 1'b0, "R1",
        {msg_valid, in_ready, bad_type}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(msg_valid === 1'b0 && msg_data === 8'd0, "R12", msg_data, 0);

    for (int c = 0; c < 32; c++)
      for (int hd = 0; hd < 2; hd++)
        send(c, hd[0]);

    // R11: reserved code, then a legal record accepted while the flag is high
    @(negedge clk);
    while (in_ready !== 1'b1) @(negedge clk);
    load(27, 0);
    in_valid = 1'b1;
    @(negedge clk);
    chk(bad_type === 1'b1 && in_ready === 1'b1, "R11", {bad_type, in_ready}, 3);
    load(19, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(bad_type === 1'b0, "R11", bad_type, 0);
    collect(19, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule